// File: doc/BRIEF.md
# Serial Display Register Writer

This block programs the registers of an external display driver chip over a three-wire write-only serial link. The link has an active-low select, a clock and a data line. A client hands over one register write at a time on a valid/ready request port. A request carries a register index, a 16-bit value and a flag that marks the request as index-only.

The block sends each message as a select-low frame of 24 bits: a command byte, then the high byte of the payload, then its low byte, with the most significant bit first. A full register write is two frames. The first frame carries the index under one command byte. The second carries the value under another. An index-only request sends only the first frame. Software uses it to point the driver at its pixel-memory port before the pixel data is streamed.

The block times every phase of a frame in units of a programmable prescaler. Between bits, the clock and data lines go back to their idle-high state. When the last frame has closed, the block pulses `done` and accepts the next request.

Top module: `serial_panel_writer`

## Requirements
- R1: After reset, and whenever no request is being served, `cs_n`, `sclk` and `sdo` are all high, `req_ready` is high and `done` is low. An asynchronous reset during a frame returns every line to this state.
- R2: Each frame holds exactly 24 bits: the 8-bit command in bits 23..16, the payload high byte in bits 15..8 and the payload low byte in bits 7..0. Bits are sent from bit 23 down to bit 0, and each bit is valid on the rising edge of `sclk`.
- R3: A request with `req_index_only` = 0 produces two separate select frames. The first is command 0x70 with the index as payload. The second is command 0x72 with the value as payload.
- R4: A request with `req_index_only` = 1 produces a single frame, command 0x70 with the index as payload. The value input has no effect.
- R5: Each bit has three phases. `sclk` is low for T_LO×TICK_DIV clocks with the data bit driven. `sclk` is then high for T_HI×TICK_DIV clocks. Finally `sclk` and `sdo` are both high for T_GAP×TICK_DIV clocks.
- R6: `sdo` does not change while `sclk` is high in the phase after a bit's rising edge.
- R7: `cs_n` falls 1+T_PRE×TICK_DIV clocks after the accepting edge of the first frame. Between the two frames of a write, `cs_n` stays high for (T_POST+T_PRE)×TICK_DIV+1 clocks. The first falling edge of `sclk` comes T_LEAD×TICK_DIV clocks after `cs_n` falls.
- R8: `cs_n` rises (T_HI+T_GAP)×TICK_DIV clocks after the last rising edge of `sclk` in a frame. `sclk` never goes low while `cs_n` is high.
- R9: `req_ready` is low from the cycle after a request is accepted until the request completes. A request held valid during that time is accepted on the first edge after `req_ready` returns.
- R10: `done` is a one-cycle pulse, issued once per request, T_POST×TICK_DIV clocks after `cs_n` rises at the end of the last frame. `req_ready` returns high in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_index_only | input | 1 | Send only the index frame |
| req_index | input | 16 | Register index |
| req_value | input | 16 | Register value |
| done | output | 1 | One-cycle pulse when a request completes |
| cs_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, idles high |

## Verification
The bench builds the block with TICK_DIV = 3 and the default phase lengths of 1, 10, 1, 1, 3 and 1 units. Every phase therefore spans several prescaler counts. A prescaler that is not restarted at a phase boundary, or a phase that is off by one count, shows up as a wrong clock count at the pins. At this size a full two-frame write takes about 800 cycles. That keeps room for a range of index and value patterns, for back-to-back requests held off by `req_ready`, and for a reset that lands in the middle of a frame.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

    // Phases of one serial frame
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_LEAD,
        PH_LO,
        PH_HI,
        PH_GAP,
        PH_POST
    } phase_e;

    // Request sequencing: index frame, then optional value frame
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_IDX_GO,
        SQ_IDX_WAIT,
        SQ_DAT_GO,
        SQ_DAT_WAIT
    } seq_e;

endpackage

// File: rtl/phase_tick.sv
module phase_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1));

endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import panel_wr_pkg::*;
#(
    parameter int DIV    = 100,
    parameter int CMD_W  = 8,
    parameter int PAY_W  = 16,
    parameter int T_PRE  = 1,
    parameter int T_LEAD = 10,
    parameter int T_LO   = 1,
    parameter int T_HI   = 1,
    parameter int T_GAP  = 3,
    parameter int T_POST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic [PAY_W-1:0] payload,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdo,
    output logic             busy,
    output logic             fin
);
    localparam int FRAME_BITS = CMD_W + PAY_W;
    localparam int BW = $clog2(FRAME_BITS);
    localparam int UW = $clog2(T_PRE + T_LEAD + T_LO + T_HI + T_GAP + T_POST + 1);

    typedef struct packed {
        phase_e                ph;
        logic [UW-1:0]         units;
        logic [BW-1:0]         bit_idx;
        logic [FRAME_BITS-1:0] sh;
    } eng_t;

    localparam eng_t ENG_RST = '{ph: PH_IDLE, units: '0, bit_idx: '0, sh: '0};

    eng_t d, q;
    logic tick;

    function automatic logic [UW-1:0] span(input phase_e p);
        case (p)
            PH_PRE:  span = UW'(T_PRE - 1);
            PH_LEAD: span = UW'(T_LEAD - 1);
            PH_LO:   span = UW'(T_LO - 1);
            PH_HI:   span = UW'(T_HI - 1);
            PH_GAP:  span = UW'(T_GAP - 1);
            PH_POST: span = UW'(T_POST - 1);
            default: span = '0;
        endcase
    endfunction

    phase_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (q.ph == PH_IDLE),
        .tick (tick)
    );

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (q.ph == PH_IDLE) begin
            if (start) begin
                d.ph      = PH_PRE;
                d.units   = span(PH_PRE);
                d.bit_idx = '0;
                d.sh      = {cmd, payload};
            end
        end else if (tick) begin
            if (q.units != '0) begin
                d.units = q.units - 1'b1;
            end else begin
                case (q.ph)
                    PH_PRE:  d.ph = PH_LEAD;
                    PH_LEAD: d.ph = PH_LO;
                    PH_LO:   d.ph = PH_HI;
                    PH_HI:   d.ph = PH_GAP;
                    PH_GAP: begin
                        if (q.bit_idx == BW'(FRAME_BITS - 1)) begin
                            d.ph = PH_POST;
                        end else begin
                            d.ph      = PH_LO;
                            d.bit_idx = q.bit_idx + 1'b1;
                            d.sh      = {q.sh[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                    default: begin
                        d.ph = PH_IDLE;
                        fin  = 1'b1;
                    end
                endcase
                d.units = span(d.ph);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign cs_n = (q.ph == PH_IDLE) || (q.ph == PH_PRE) || (q.ph == PH_POST);
    assign sclk = (q.ph != PH_LO);
    assign sdo  = ((q.ph == PH_LO) || (q.ph == PH_HI)) ? q.sh[FRAME_BITS-1] : 1'b1;
    assign busy = (q.ph != PH_IDLE);

    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_HI) |-> $stable(sdo));

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (q.bit_idx == BW'(FRAME_BITS - 1)));

    // R7
    lead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(q.ph) == PH_PRE));

endmodule

// File: rtl/serial_panel_writer.sv
module serial_panel_writer
    import panel_wr_pkg::*;
#(
    parameter int             TICK_DIV = 100,
    parameter int             PAY_W    = 16,
    parameter int             CMD_W    = 8,
    parameter logic [CMD_W-1:0] CMD_IDX = 8'h70,
    parameter logic [CMD_W-1:0] CMD_VAL = 8'h72,
    parameter int             T_PRE    = 1,
    parameter int             T_LEAD   = 10,
    parameter int             T_LO     = 1,
    parameter int             T_HI     = 1,
    parameter int             T_GAP    = 3,
    parameter int             T_POST   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_index_only,
    input  logic [PAY_W-1:0] req_index,
    input  logic [PAY_W-1:0] req_value,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdo
);
    typedef struct packed {
        seq_e             st;
        logic             only;
        logic [PAY_W-1:0] idx;
        logic [PAY_W-1:0] val;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: SQ_IDLE, only: 1'b0, idx: '0, val: '0, done: 1'b0};

    seq_t d, q;
    logic             eng_start, eng_busy, eng_fin;
    logic [CMD_W-1:0] eng_cmd;
    logic [PAY_W-1:0] eng_pay;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        req_ready = (q.st == SQ_IDLE);
        eng_start = (q.st == SQ_IDX_GO) || (q.st == SQ_DAT_GO);
        eng_cmd   = (q.st == SQ_DAT_GO) ? CMD_VAL : CMD_IDX;
        eng_pay   = (q.st == SQ_DAT_GO) ? q.val : q.idx;
        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.st   = SQ_IDX_GO;
                    d.only = req_index_only;
                    d.idx  = req_index;
                    d.val  = req_value;
                end
            end
            SQ_IDX_GO: d.st = SQ_IDX_WAIT;
            SQ_IDX_WAIT: begin
                if (eng_fin) begin
                    if (q.only) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = SQ_DAT_GO;
                    end
                end
            end
            SQ_DAT_GO: d.st = SQ_DAT_WAIT;
            SQ_DAT_WAIT: begin
                if (eng_fin) begin
                    d.st   = SQ_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign done = q.done;

    frame_engine #(
        .DIV   (TICK_DIV),
        .CMD_W (CMD_W),
        .PAY_W (PAY_W),
        .T_PRE (T_PRE),
        .T_LEAD(T_LEAD),
        .T_LO  (T_LO),
        .T_HI  (T_HI),
        .T_GAP (T_GAP),
        .T_POST(T_POST)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .cmd    (eng_cmd),
        .payload(eng_pay),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdo    (sdo),
        .busy   (eng_busy),
        .fin    (eng_fin)
    );

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    no_ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && cs_n));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

endmodule

// File: tb/serial_panel_writer_tb.sv
`timescale 1ns/1ps
module serial_panel_writer_tb;

    localparam int DIV = 3;
    localparam int TPRE = 1, TLEAD = 10, TLO = 1, THI = 1, TGAP = 3, TPOST = 1;

    // {index_only, index, value}
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h0010, 16'h4444},
        {1'b0, 16'h0001, 16'h0000},
        {1'b0, 16'h0044, 16'hFFFF},
        {1'b1, 16'h0022, 16'h0000},
        {1'b0, 16'hA55A, 16'h5AA5},
        {1'b1, 16'h8001, 16'h1234}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_index_only = 1'b0;
    logic [15:0] req_index = '0, req_value = '0;
    logic req_ready, done, cs_n, sclk, sdo;

    always #2.5 clk = ~clk;

    serial_panel_writer #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index_only(req_index_only), .req_index(req_index), .req_value(req_value),
        .done(done), .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state
    int acc_cyc = 0, acc_frames = 0;
    int nframes = 0, done_cnt = 0, done_cyc = 0;
    int mon_err = 0, len_err = 0, seq_err = 0;
    logic [23:0] frames [64];
    logic [23:0] shreg = '0;
    int nbits = 0, cs_fall = 0, cs_rise = 0, rise_c = 0, fall_c = 0;
    logic first_fall = 1'b0, capbit = 1'b1, prev_cs = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b1; prev_done = 1'b0;
        end else begin
            if (cs_n && (!sclk || !sdo)) mon_err++;                 // R1 R8
            if (!cs_n && req_ready) seq_err++;                      // R9
            if (prev_cs && !cs_n) begin                             // R7
                cs_fall = cyc; first_fall = 1'b1; nbits = 0;
                if (nframes == acc_frames) begin
                    if (cyc - acc_cyc != 1 + TPRE*DIV) mon_err++;
                end else if (cyc - cs_rise != (TPOST + TPRE)*DIV + 1) mon_err++;
            end
            if (prev_sclk && !sclk) begin                           // R5 R7
                if (first_fall) begin
                    if (cyc - cs_fall != TLEAD*DIV) mon_err++;
                end else if (cyc - rise_c != (THI + TGAP)*DIV) mon_err++;
                fall_c = cyc; first_fall = 1'b0;
            end
            if (!prev_sclk && sclk && !cs_n) begin                  // R2 R5
                if (cyc - fall_c != TLO*DIV) mon_err++;
                rise_c = cyc; capbit = sdo; shreg = {shreg[22:0], sdo}; nbits++;
            end
            if (sclk && !cs_n && !first_fall) begin                 // R5 R6
                if (cyc - rise_c < THI*DIV) begin
                    if (sdo != capbit) mon_err++;
                end else if (!sdo) mon_err++;
            end
            if (!prev_cs && cs_n) begin                             // R8 R2
                if (cyc - rise_c != (THI + TGAP)*DIV) mon_err++;
                if (nbits != 24) len_err++;
                frames[nframes % 64] = shreg; nframes++; cs_rise = cyc;
            end
            if (done) begin                                         // R10
                done_cnt++; done_cyc = cyc;
                if (prev_done) seq_err++;
                if (cyc - cs_rise != TPOST*DIV) seq_err++;
            end
            prev_cs = cs_n; prev_sclk = sclk; prev_done = done;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic only, input logic [15:0] idx, input logic [15:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_index_only = only; req_index = idx; req_value = val;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc; acc_frames = nframes;
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset lines", {28'd0, cs_n, sclk, sdo, req_ready}, 32'hF);
        check("R1 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {27'd0, cs_n, sclk, sdo, req_ready, done}, 32'h1E);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            int b, d0, e0, s0, l0;
            logic only;
            logic [15:0] idx, val;
            only = VEC[i][32]; idx = VEC[i][31:16]; val = VEC[i][15:0];
            e0 = mon_err; s0 = seq_err; l0 = len_err; d0 = done_cnt;
            b = nframes;
            send(only, idx, val);
            wait_done(d0);
            check(only ? "R4 frame count" : "R3 frame count", nframes - b, only ? 1 : 2);
            check("R2 R3 index frame", {8'd0, frames[b % 64]}, {8'd0, 8'h70, idx});
            if (!only)
                check("R3 value frame", {8'd0, frames[(b + 1) % 64]}, {8'd0, 8'h72, val});
            check("R2 bit count", len_err - l0, 0);
            check("R5 R6 R7 R8 timing", mon_err - e0, 0);
            check("R9 R10 handshake", seq_err - s0, 0);
            check("R10 done once", done_cnt - d0, 1);
        end

        // R9: second request held valid while the first is busy
        begin
            int d0, b, a1, e0;
            d0 = done_cnt; b = nframes; e0 = mon_err + seq_err;
            send(1'b0, 16'h0003, 16'h6020);
            a1 = acc_cyc;
            send(1'b0, 16'h0007, 16'h0073);
            check("R9 held request accepted after done", acc_cyc - done_cyc, 1);
            check("R9 held request not early", {31'd0, (acc_cyc - a1) > 100}, 32'd1);
            wait_done(d0 + 1);
            check("R9 four frames", nframes - b, 4);
            check("R9 frame order", {8'd0, frames[(b + 2) % 64]}, {8'd0, 24'h700007});
            check("R9 last value", {8'd0, frames[(b + 3) % 64]}, {8'd0, 24'h720073});
            check("R9 R10 clean", mon_err + seq_err - e0, 0);
            check("R10 two dones", done_cnt - d0, 2);
        end

        // R1: reset in the middle of a frame
        begin
            int d0;
            d0 = done_cnt;
            send(1'b0, 16'hFFFF, 16'hFFFF);
            repeat (60) @(negedge clk);
            check("R1 mid frame active", {31'd0, cs_n}, 32'd0);
            rst_n = 1'b0;
            #1;
            check("R1 reset mid frame", {28'd0, cs_n, sclk, sdo, req_ready}, 32'hF);
            @(negedge clk);
            rst_n = 1'b1;
            repeat (1200) @(negedge clk);
            check("R1 no done after abort", done_cnt - d0, 0);
            check("R1 idle after abort", {27'd0, cs_n, sclk, sdo, req_ready, done}, 32'h1E);
        end

        // R4: index-only after abort still works, value ignored
        begin
            int d0, b;
            d0 = done_cnt; b = nframes;
            send(1'b1, 16'h0022, 16'hBEEF);
            wait_done(d0);
            check("R4 single frame", nframes - b, 1);
            check("R4 index frame", {8'd0, frames[b % 64]}, {8'd0, 24'h700022});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule